// File: doc/BRIEF.md
# Addressed Switch-State Register

This block sits on a backplane and captures the fast analog-switch control bits used for correlated double sampling of a video channel. A timing sequencer places a 16-bit word on the bus and raises a write strobe. The block detects the rising edge of that strobe inside its own clock domain. If the top four bits of the word equal a board address set by jumpers, the block stores the seven low bits of the word. It ignores words sent to any other address.

The stored bits drive five switch controls: integrator reset, signal polarity, integrate enable, conversion start and result transfer. The block also makes one-clock pulses when the conversion-start bit or the transfer bit goes from low to high between two accepted writes.

Top module: `sw_state_latch`

## Requirements
- R1: After reset, every stored control bit is 1, so `rst_int_n`, `pol_n`, `integ_n`, `conv_lvl` and `xfer_lvl` read 1, and `conv_pulse` and `xfer_pulse` read 0.
- R2: A write is accepted only in the clock cycle that first samples `wr_strobe` high after a sample of it low. A strobe that stays high does not load the register again.
- R3: A write is accepted only when `bus_word[15:12]` equals `board_addr`. On a mismatch, all outputs keep their previous values.
- R4: An accepted write stores `bus_word[6:0]`. Bits 11 to 7 of the word have no effect on any output.
- R5: `rst_int_n` follows stored bit 0, the integrator reset, which is active low.
- R6: `pol_n` follows stored bit 3, where 0 selects the inverted signal. `integ_n` follows stored bit 4, the integrate enable, which is active low.
- R7: `conv_lvl` follows stored bit 5. `conv_pulse` is high for exactly one clock when an accepted write changes bit 5 from 0 to 1. It stays low when an accepted write leaves bit 5 at 1.
- R8: `xfer_lvl` follows stored bit 6. `xfer_pulse` is high for exactly one clock when an accepted write changes bit 6 from 0 to 1.
- R9: Outputs change one clock after the strobe edge is sampled. A synchronizer of `SYNC_STAGES` flops sits in front of the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| board_addr | input | 4 | Address set by jumpers |
| bus_word | input | 16 | Backplane switch-state word |
| wr_strobe | input | 1 | Write strobe, asynchronous to `clk` |
| rst_int_n | output | 1 | Integrator reset, active low |
| pol_n | output | 1 | Polarity select, 0 selects the inverted signal |
| integ_n | output | 1 | Integrate enable, active low |
| conv_lvl | output | 1 | Conversion-start level |
| conv_pulse | output | 1 | One-clock pulse on a 0-to-1 change of the start bit |
| xfer_lvl | output | 1 | Transfer level |
| xfer_pulse | output | 1 | One-clock pulse on a 0-to-1 change of the transfer bit |

## Verification
The bench holds the strobe high across several words. A design that loads on level rather than on edge would pick up the later words. The bench sends words with a wrong address and with noise in bits 11 to 7; a design that decodes loosely would change the switch outputs. It also repeats a write with the start bit already at 1. A pulse generator keyed to the level instead of the change would then fire a spurious conversion. The bench also issues a falling 1-to-0 write, which must give no pulse.

// File: rtl/sw_state_pkg.sv
package sw_state_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int STATE_W = 7;
  localparam int BIT_RST  = 0;
  localparam int BIT_POL  = 3;
  localparam int BIT_INTG = 4;
  localparam int BIT_CONV = 5;
  localparam int BIT_XFER = 6;
endpackage

// File: rtl/sw_strobe_edge.sv
module sw_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sw_state_reg.sv
module sw_state_reg
  import sw_state_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] q,
  output logic               conv_pulse,
  output logic               xfer_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q          <= '1;
      conv_pulse <= 1'b0;
      xfer_pulse <= 1'b0;
    end else begin
      conv_pulse <= load & din[BIT_CONV] & ~q[BIT_CONV];
      xfer_pulse <= load & din[BIT_XFER] & ~q[BIT_XFER];
      if (load) q <= din;
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  a_r7_conv_rise: assert property (@(posedge clk) disable iff (rst)
    conv_pulse |-> q[BIT_CONV] && !$past(q[BIT_CONV]));
  a_r8_xfer_rise: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |-> q[BIT_XFER] && !$past(q[BIT_XFER]));
  a_r7_conv_one: assert property (@(posedge clk) disable iff (rst)
    conv_pulse |=> !conv_pulse);
endmodule

// File: rtl/sw_state_latch.sv
module sw_state_latch
  import sw_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] board_addr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              wr_strobe,
  output logic              rst_int_n,
  output logic              pol_n,
  output logic              integ_n,
  output logic              conv_lvl,
  output logic              conv_pulse,
  output logic              xfer_lvl,
  output logic              xfer_pulse
);
  logic               rise;
  logic               load;
  logic [STATE_W-1:0] st;

  sw_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .strobe_in(wr_strobe), .rise(rise));

  assign load = rise && (bus_word[WORD_W-1 -: ADDR_W] == board_addr);

  sw_state_reg u_reg (
    .clk(clk), .rst(rst), .load(load), .din(bus_word[STATE_W-1:0]),
    .q(st), .conv_pulse(conv_pulse), .xfer_pulse(xfer_pulse));

  assign rst_int_n = st[BIT_RST];
  assign pol_n     = st[BIT_POL];
  assign integ_n   = st[BIT_INTG];
  assign conv_lvl  = st[BIT_CONV];
  assign xfer_lvl  = st[BIT_XFER];

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> st == $past(bus_word[STATE_W-1:0]));
  a_r1_reset: assert property (@(posedge clk)
    $past(rst) |-> (st == '1) && !conv_pulse && !xfer_pulse);
endmodule

// File: tb/test_sw_state_latch.sv
module test_sw_state_latch;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 1'b0, rst = 1'b1, wr_strobe = 1'b0;
  logic [3:0]  board_addr = 4'h5;
  logic [15:0] bus_word = '0;
  logic rst_int_n, pol_n, integ_n, conv_lvl, conv_pulse, xfer_lvl, xfer_pulse;
  int checks = 0, errors = 0;
  logic [6:0] model = 7'h7F;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_state_latch i_sw_state_latch (.*);

  function automatic logic [4:0] levels(input logic [6:0] s);
    return {s[6], s[5], s[4], s[3], s[0]};
  endfunction

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {2'b00, xfer_lvl, conv_lvl, integ_n, pol_n, rst_int_n};
  endfunction

  task automatic chk_lv(input string req);
    chk(req, outs(), {2'b00, levels(model)});
  endtask

  // Drive the word and raise the strobe, with inputs changing at negedge.
  // Two sync flops and one edge flop put the rise on the third posedge;
  // the register updates on that edge, so sample one negedge later.
  task automatic wr(input logic [15:0] w, input string req,
                    input logic exp_c, input logic exp_x);
    @(negedge clk);
    bus_word = w;
    wr_strobe = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk);
    if (w[15:12] == board_addr) model = w[6:0];
    chk_lv(req);
    chk({req, " conv"}, {6'd0, conv_pulse}, {6'd0, exp_c});
    chk({req, " xfer"}, {6'd0, xfer_pulse}, {6'd0, exp_x});
    @(negedge clk);
    chk({req, " pulse end"}, {5'd0, conv_pulse, xfer_pulse}, 7'd0);
    wr_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_lv("R1 reset levels");
    chk("R1 reset pulses", {5'd0, conv_pulse, xfer_pulse}, 7'd0);
    // R5/R6 active-low controls, R7/R8 rising edges
    wr(16'h5000, "R5 R6 all low", 1'b0, 1'b0);
    wr(16'h5020, "R7 conv rise", 1'b1, 1'b0);
    wr(16'h5020, "R7 conv repeat no pulse", 1'b0, 1'b0);
    wr(16'h5040, "R8 xfer rise", 1'b0, 1'b1);
    wr(16'h5000, "R8 falling no pulse", 1'b0, 1'b0);
    wr(16'h5009, "R5 R6 pol and reset high", 1'b0, 1'b0);
    // R3 address mismatch
    wr(16'hA07F, "R3 wrong address", 1'b0, 1'b0);
    // R4 noise in bits 11..7
    wr(16'h5F80 | 16'h0011, "R4 upper noise", 1'b0, 1'b0);
    // R2 held strobe: second word must not load
    @(negedge clk);
    bus_word = 16'h5060; wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    model = 7'h60;
    bus_word = 16'h5001;
    repeat (5) @(negedge clk);
    chk_lv("R2 held strobe no reload");
    wr_strobe = 1'b0; repeat (3) @(negedge clk);
    // R9 latency: one edge before load nothing has changed
    @(negedge clk);
    bus_word = 16'h507F; wr_strobe = 1'b1;
    repeat (2) @(negedge clk);
    chk_lv("R9 not yet loaded");
    @(negedge clk);
    model = 7'h7F;
    chk_lv("R9 loaded after sync");
    wr_strobe = 1'b0; repeat (3) @(negedge clk);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] w;
      logic [6:0] prev;
      logic hit;
      w = 16'($urandom);
      if ($urandom % 2) w[15:12] = board_addr;
      prev = model;
      hit = (w[15:12] == board_addr);
      wr(w, "R4 R7 R8 random",
         hit & w[5] & ~prev[5], hit & w[6] & ~prev[6]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule